// File: doc/BRIEF.md
# Multi-Bank Event Interrupt Aggregator

The block collects single-cycle event pulses into three 32-bit sticky pending words. Three independent mask banks each hold one enable word per pending word. Each bank drives its own level-sensitive interrupt line. Software reads every pending and mask word over a simple word-wide register bus. It acknowledges events by writing ones to the pending words.

A bank's line is high while at least one pending bit is set whose enable bit in that bank is also set. A line does not latch on its own. It falls in the cycle after software clears the last enabled pending bit, and it rises in the cycle after a mask write enables a bit that is already pending. The three lines are ordered for a downstream priority controller: `irq_a` feeds level 13, `irq_b` feeds level 11 and `irq_c` feeds level 9.

Top module: `evagg_top`

## Requirements
- R1: When `rst_n` is low at a clock edge, every pending word and every mask word becomes zero, and all three interrupt lines are low after that edge.
- R2: An event pulse on bit `w*32+k` of `evt_set` sets bit k of pending word w at the next edge. The bit stays set until software clears it, and no pending bit becomes set without an event.
- R3: A bus write to pending word w (offset 0x00, 0x04 or 0x08 for w = 0, 1, 2) clears exactly the bits written as one and keeps all other bits of that word.
- R4: When an event pulse and a clearing write hit the same pending bit at the same edge, the bit ends up set.
- R5: Mask words are plain read/write. Bank A is at 0x10/0x14/0x18, bank B at 0x20/0x24/0x28 and bank C at 0x30/0x34/0x38, each covering pending words 0, 1, 2 in that order. A read returns the current value combinationally.
- R6: `irq_a` is high exactly when the OR over w of (pending[w] AND maskA[w]) is nonzero. `irq_b` follows the same rule with bank B, and `irq_c` with bank C.
- R7: An interrupt line stays high as long as one of its enabled pending bits is set. It drops in the cycle after the write that clears the last such bit.
- R8: A mask write that enables a bit that is already pending raises that bank's line in the cycle after the write.
- R9: The following addresses are unmapped: any address with bits [1:0] nonzero, any address with bits [7:6] nonzero, and any address whose word index (bits [3:2]) is 3. Reads from them return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | 96 | Event set pulses; bits [w*32+31:w*32] target pending word w |
| bus_addr | input | 8 | Register byte address |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_a | output | 1 | Bank A level interrupt (priority 13) |
| irq_b | output | 1 | Bank B level interrupt (priority 11) |
| irq_c | output | 1 | Bank C level interrupt (priority 9) |

## Verification
Several rules are checked by assertions on every cycle:
- no pending bit appears without an event;
- no pending bit vanishes unless it was written as one to its own word;
- a same-edge event always survives;
- a line rises only after an event or a write;
- a line never falls in a cycle without a write.

The bench's scenarios cover the rest. They confirm the exact value of each line against a model across all three banks. They show the mask readback layout, the zero reads and dead writes of unmapped addresses, and a line raised purely by a mask write over an existing pending bit.

// File: rtl/evagg_pkg.sv
// Package: shared sizing and register-map constants for the event aggregator.
// Assumes a 32-bit word bus with byte addresses; the group and index fields
// of the address are fixed by the register map.
package evagg_pkg;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = 3;
    localparam int NBANKS  = 3;
    localparam int ADDR_W  = 8;
    localparam int GRP_LSB = 4;
    localparam int IDX_LSB = 2;

    typedef enum logic [1:0] {
        GRP_PEND  = 2'd0,
        GRP_MASKA = 2'd1,
        GRP_MASKB = 2'd2,
        GRP_MASKC = 2'd3
    } grp_e;
endpackage

// File: rtl/evagg_pending.sv
// Module: sticky pending words. Each bit is set by an event pulse and cleared
// by a write-one-to-clear strobe; a same-edge set beats the clear.
// Assumes write enables are one-hot at most and come from the register decoder.
module evagg_pending #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    localparam int FLAT_W = WORD_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] set_flat,
    input  logic [NWORDS-1:0] wen,
    input  logic [WORD_W-1:0] wdata,
    output logic [FLAT_W-1:0] pend_flat
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] clr;
        logic [WORD_W-1:0] word_q;

        // Clear mask for this word: written ones when addressed.
        always_comb clr = wen[w] ? wdata : '0;

        // Pending word update: clear first, then OR in new events.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= (word_q & ~clr) | set_flat[w*WORD_W +: WORD_W];
        end

        assign pend_flat[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/evagg_maskbank.sv
// Module: one mask bank. Holds one enable word per pending word and reduces
// (pending AND mask) over all words to a single level interrupt.
// Assumes the interrupt is consumed as a level, so it is left combinational.
module evagg_maskbank #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    localparam int FLAT_W = WORD_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWORDS-1:0] wen,
    input  logic [WORD_W-1:0] wdata,
    input  logic [FLAT_W-1:0] pend_flat,
    output logic [FLAT_W-1:0] mask_flat,
    output logic              irq
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] mask_q;

        // Mask word storage: plain read/write register.
        always_ff @(posedge clk) begin
            if (!rst_n)     mask_q <= '0;
            else if (wen[w]) mask_q <= wdata;
        end

        assign mask_flat[w*WORD_W +: WORD_W] = mask_q;
    end

    logic [WORD_W-1:0] hit;

    // Reduction: OR of enabled pending bits across all words.
    always_comb begin
        hit = '0;
        for (int w = 0; w < NWORDS; w++)
            hit |= pend_flat[w*WORD_W +: WORD_W] & mask_flat[w*WORD_W +: WORD_W];
        irq = |hit;
    end
endmodule

// File: rtl/evagg_regif.sv
// Module: register decoder. Turns a byte address into per-word write enables
// for the pending words and each mask bank, and muxes read data.
// Assumes word access; any address outside the map reads zero and writes nothing.
module evagg_regif
    import evagg_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    parameter int NBANKS = 3,
    parameter int ADDR_W = 8,
    localparam int FLAT_W = WORD_W * NWORDS
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wen,
    input  logic [FLAT_W-1:0]        pend_flat,
    input  logic [NBANKS*FLAT_W-1:0] mask_flat,
    output logic [NWORDS-1:0]        pend_wen,
    output logic [NBANKS*NWORDS-1:0] mask_wen,
    output logic [WORD_W-1:0]        rdata
);
    logic [1:0] grp;
    logic [1:0] idx;
    logic       hit;
    int         bank;

    // Field extraction and map membership.
    always_comb begin
        grp  = addr[GRP_LSB +: 2];
        idx  = addr[IDX_LSB +: 2];
        bank = int'(grp) - 1;
        hit  = (addr[ADDR_W-1:GRP_LSB+2] == '0) && (addr[IDX_LSB-1:0] == '0)
               && (int'(idx) < NWORDS)
               && ((grp == GRP_PEND) || (bank < NBANKS));
    end

    // Write strobe fan-out to the addressed word.
    always_comb begin
        pend_wen = '0;
        mask_wen = '0;
        if (wen && hit) begin
            if (grp == GRP_PEND) pend_wen[idx] = 1'b1;
            else                 mask_wen[bank*NWORDS + int'(idx)] = 1'b1;
        end
    end

    // Read data mux.
    always_comb begin
        rdata = '0;
        if (hit) begin
            if (grp == GRP_PEND) rdata = pend_flat[int'(idx)*WORD_W +: WORD_W];
            else                 rdata = mask_flat[(bank*NWORDS + int'(idx))*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/evagg_top.sv
// Module: top of the event interrupt aggregator. Pending words, three mask
// banks and the register decoder; lines ordered A, B, C for priorities 13, 11, 9.
// Assumes the event pulses and the bus share the single clock.
module evagg_top
    import evagg_pkg::*;
#(
    parameter int WORD_W_P = WORD_W,
    parameter int NWORDS_P = NWORDS,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WORD_W_P*NWORDS_P-1:0] evt_set,
    input  logic [ADDR_W_P-1:0]          bus_addr,
    input  logic                         bus_wen,
    input  logic [WORD_W_P-1:0]          bus_wdata,
    output logic [WORD_W_P-1:0]          bus_rdata,
    output logic                         irq_a,
    output logic                         irq_b,
    output logic                         irq_c
);
    localparam int FLAT_W = WORD_W_P * NWORDS_P;

    logic [FLAT_W-1:0]          pend_flat;
    logic [NBANKS*FLAT_W-1:0]   mask_flat;
    logic [NWORDS_P-1:0]        pend_wen;
    logic [NBANKS*NWORDS_P-1:0] mask_wen;
    logic [NBANKS-1:0]          irq_vec;

    evagg_regif #(
        .WORD_W(WORD_W_P), .NWORDS(NWORDS_P), .NBANKS(NBANKS), .ADDR_W(ADDR_W_P)
    ) u_regif (
        .addr(bus_addr), .wen(bus_wen), .pend_flat(pend_flat), .mask_flat(mask_flat),
        .pend_wen(pend_wen), .mask_wen(mask_wen), .rdata(bus_rdata)
    );

    evagg_pending #(.WORD_W(WORD_W_P), .NWORDS(NWORDS_P)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_flat(evt_set), .wen(pend_wen),
        .wdata(bus_wdata), .pend_flat(pend_flat)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        evagg_maskbank #(.WORD_W(WORD_W_P), .NWORDS(NWORDS_P)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wen(mask_wen[b*NWORDS_P +: NWORDS_P]), .wdata(bus_wdata),
            .pend_flat(pend_flat),
            .mask_flat(mask_flat[b*FLAT_W +: FLAT_W]),
            .irq(irq_vec[b])
        );
    end

    assign irq_a = irq_vec[0];
    assign irq_b = irq_vec[1];
    assign irq_c = irq_vec[2];
endmodule

// File: rtl/evagg_chk.sv
// Module: assertion checker bound to evagg_top. Watches the ports and the
// pending words; it has its own decode of the pending-word addresses.
module evagg_chk #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    parameter int ADDR_W = 8,
    localparam int FLAT_W = WORD_W * NWORDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLAT_W-1:0] evt_set,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              irq_a,
    input logic              irq_b,
    input logic              irq_c,
    input logic [FLAT_W-1:0] pend_flat
);
    logic [FLAT_W-1:0] clr_vec;

    // Bits a write is allowed to clear this cycle.
    always_comb begin
        clr_vec = '0;
        for (int w = 0; w < NWORDS; w++)
            if (bus_wen && bus_addr == ADDR_W'(w*4))
                clr_vec[w*WORD_W +: WORD_W] = bus_wdata;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pend_flat == '0 && !irq_a && !irq_b && !irq_c)); // R1
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_flat & ~$past(pend_flat) & ~$past(evt_set)) == '0)); // R2
    AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend_flat) & ~pend_flat & ~$past(clr_vec)) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((pend_flat & $past(evt_set)) == $past(evt_set))); // R4
    AST_IRQ_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> $past(evt_set != '0 || bus_wen)); // R6
    AST_IRQ_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_b) |-> $past(evt_set != '0 || bus_wen)); // R6
    AST_IRQ_C_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_c) |-> $past(evt_set != '0 || bus_wen)); // R6
    AST_IRQ_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a && !bus_wen) |=> irq_a); // R7
    AST_IRQ_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_b && !bus_wen) |=> irq_b); // R7
    AST_IRQ_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_c && !bus_wen) |=> irq_c); // R7
endmodule

bind evagg_top evagg_chk #(.WORD_W(WORD_W_P), .NWORDS(NWORDS_P), .ADDR_W(ADDR_W_P)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .irq_a(irq_a), .irq_b(irq_b),
    .irq_c(irq_c), .pend_flat(pend_flat)
);

// File: tb/sim_evagg_top.sv
module sim_evagg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] evt_set = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a, irq_b, irq_c;

    int checks = 0;
    int errors = 0;

    logic [31:0] pm [3];
    logic [31:0] mm [3][3];

    always #5 clk = ~clk;

    evagg_top u0 (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c)
    );

    function automatic logic exp_irq(int b);
        logic [31:0] acc = '0;
        for (int w = 0; w < 3; w++) acc |= pm[w] & mm[b][w];
        return |acc;
    endfunction

    function automatic logic mapped(logic [7:0] a);
        return a[1:0] == 2'd0 && a[7:6] == 2'd0 && a[3:2] != 2'd3;
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        if (!mapped(a)) return '0;
        if (a[5:4] == 2'd0) return pm[a[3:2]];
        return mm[a[5:4] - 2'd1][a[3:2]];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_irqs(string req);
        check(req, {31'd0, irq_a}, {31'd0, exp_irq(0)});
        check(req, {31'd0, irq_b}, {31'd0, exp_irq(1)});
        check(req, {31'd0, irq_c}, {31'd0, exp_irq(2)});
    endtask

    task automatic read_chk(string req, logic [7:0] a);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_rd(a));
    endtask

    // One clock: drive at negedge, update model at posedge, check irqs at negedge.
    task automatic cyc(string req, logic [95:0] evt, logic wen, logic [7:0] a, logic [31:0] d);
        evt_set = evt; bus_wen = wen; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        for (int w = 0; w < 3; w++) begin
            logic [31:0] clr = (wen && a == 8'(w*4)) ? d : '0;
            pm[w] = (pm[w] & ~clr) | evt[w*32 +: 32];
        end
        if (wen && mapped(a) && a[5:4] != 2'd0) mm[a[5:4] - 2'd1][a[3:2]] = d;
        @(negedge clk);
        evt_set = '0; bus_wen = 1'b0;
        check_irqs(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        for (int w = 0; w < 3; w++) begin
            pm[w] = '0;
            for (int b = 0; b < 3; b++) mm[b][w] = '0;
        end
        @(negedge clk);
        check_irqs("R1");
        for (int g = 0; g < 4; g++)
            for (int i = 0; i < 3; i++) begin
                bus_addr = 8'(g*16 + i*4);
                #1;
                check("R1", bus_rdata, 32'd0);
            end
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R5: mask readback in each bank
        cyc("R5", '0, 1'b1, 8'h14, 32'hA5A5_0F0F);
        cyc("R5", '0, 1'b1, 8'h20, 32'h1234_5678);
        cyc("R5", '0, 1'b1, 8'h38, 32'h0000_0001);
        read_chk("R5", 8'h14);
        read_chk("R5", 8'h20);
        read_chk("R5", 8'h38);
        check("R5", bus_rdata, 32'h0000_0001);
        cyc("R5", '0, 1'b1, 8'h14, 32'h0);
        cyc("R5", '0, 1'b1, 8'h20, 32'h0);
        cyc("R5", '0, 1'b1, 8'h38, 32'h0);

        // R2: event sets pending bit 7 of word 2, sticky
        cyc("R2", 96'h80 << 64, 1'b0, 8'h00, 32'h0);
        cyc("R2", '0, 1'b0, 8'h00, 32'h0);
        read_chk("R2", 8'h08);
        check("R2", bus_rdata, 32'h0000_0080);

        // R8: enabling an already-pending bit raises irq_c only
        cyc("R8", '0, 1'b1, 8'h38, 32'h0000_0080);
        check("R8", {31'd0, irq_c}, 32'd1);
        check("R6", {30'd0, irq_a, irq_b}, 32'd0);

        // R3: writing ones elsewhere keeps bit 7; R7: clearing it drops the line
        cyc("R3", '0, 1'b1, 8'h08, 32'h0000_0001);
        read_chk("R3", 8'h08);
        check("R3", bus_rdata, 32'h0000_0080);
        check("R7", {31'd0, irq_c}, 32'd1);
        cyc("R7", '0, 1'b1, 8'h08, 32'h0000_0080);
        check("R7", {31'd0, irq_c}, 32'd0);

        // R4: set and clear on bit 3 of word 0 at the same edge
        cyc("R4", 96'h8, 1'b1, 8'h00, 32'h0000_0008);
        read_chk("R4", 8'h00);
        check("R4", bus_rdata, 32'h0000_0008);

        // R9: unmapped addresses read zero and writes go nowhere
        cyc("R9", '0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
        cyc("R9", '0, 1'b1, 8'h50, 32'hFFFF_FFFF);
        cyc("R9", '0, 1'b1, 8'h11, 32'hFFFF_FFFF);
        cyc("R9", '0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
        read_chk("R9", 8'h1C);
        read_chk("R9", 8'h50);
        read_chk("R9", 8'h11);
        for (int g = 0; g < 4; g++)
            for (int i = 0; i < 3; i++) read_chk("R9", 8'(g*16 + i*4));
        read_chk("R9", 8'h00);
        check("R9", bus_rdata, 32'h0000_0008);

        // R6: random mix of events, clears, mask writes and stray writes
        for (int n = 0; n < 600; n++) begin
            logic [95:0] evt;
            logic [7:0]  a;
            logic [31:0] d;
            int          op;
            evt = '0;
            for (int w = 0; w < 3; w++)
                evt[w*32 +: 32] = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
            op = int'($urandom % 5);
            d  = $urandom & $urandom;
            case (op)
                1: a = 8'(($urandom % 3) * 4);
                2: a = 8'(16 * (1 + $urandom % 3) + 4 * ($urandom % 3));
                3: a = 8'($urandom);
                default: a = 8'(($urandom % 3) * 4);
            endcase
            if (op == 1 || op == 4) d = $urandom;
            cyc("R6", evt, op != 0, a, d);
            read_chk("R5", (n % 2 == 0) ? 8'(16 * ($urandom % 4) + 4 * ($urandom % 3)) : 8'($urandom));
        end

        // R1: reset in mid-run clears everything
        do_reset();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule